// File: doc/BRIEF.md
# Block-Write Colour Expansion Unit

This unit sits on the write side of a graphics DRAM controller, between the command and data pins and a behavioural memory model. It holds one colour word and one per-bit write mask, both shared by all banks and loaded by special register-load commands that take their value from the data bus. Each write command produces one registered write descriptor. The descriptor gives the data word, the column, a column-by-lane enable map and a per-bit enable word.

There are two kinds of write. In a plain write, the bus word goes to one column. In a block write, the bus word does not carry pixel data. Bit `c` of every byte lane selects whether column `c` of an aligned group of eight columns receives that lane of the colour word. Each bank also has a write-per-bit flag. It is fixed when the bank's row is opened and cleared when the row closes. While it is set, writes to that bank are gated by the mask word. The unit also reports a load attempted while the bus is busy or with both register selects set, and a precharge that follows a block write to the same bank too soon.

Top module: `blkwr_expand`

## Requirements
- R1: The command encoding on `cmd` is 0 idle, 1 activate, 2 write, 3 precharge and 4 register load. One cycle after a write command, `wrValid` is 1. After any other command, `wrValid` is 0 and every descriptor field is zero.
- R2: A write with `specialFn`=0 is a plain write. `wrData` equals `dataIn` and `wrCol` equals `addrIn[7:0]`. Bit `L` of `wrColLaneEn` (slot 0, bits 7:0) is `~laneMask[L]`, and all other slots are 0.
- R3: An activate with `specialFn`=1 puts its bank in write-per-bit mode, and an activate with `specialFn`=0 clears that mode. While the mode is set, `wrBitEn` is the mask word for both plain and block writes to that bank; otherwise it is all ones. The mode is cleared by a precharge of that bank, or by any precharge with `addrIn[8]`=1.
- R4: The write-per-bit mode is held separately for each bank. The colour and mask words are shared by all banks.
- R5: A write with `specialFn`=1 is a block write, and it raises `wrBlock`. `wrData` is the colour word, and `wrCol` is `addrIn[7:0]` with bits 2:0 forced to 0. Bit `c*8+L` of `wrColLaneEn` equals `dataIn[8*L+c] & ~laneMask[L]`, so lane bit 0 enables column offset 0 and bit 7 enables offset 7.
- R6: A register load with `specialFn`=1 and `busBusy`=0 copies `dataIn` into the colour word when `addrIn[6]`=1, or into the mask word when `addrIn[5]`=1. A write in the next cycle already uses the new value.
- R7: A register load with `specialFn`=1 raises `smrsErr` for one cycle and changes neither word when `busBusy`=1 or when `addrIn[6]` and `addrIn[5]` are both 1.
- R8: A register load with `specialFn`=0 changes neither word and raises no error.
- R9: A precharge that reaches a bank in the cycle right after a block write to that bank raises `ruleErr` for one cycle. Back-to-back block writes, and a precharge two or more cycles after a block write, raise nothing.
- R10: After reset, all outputs are 0, the colour and mask words are 0, and no bank is in write-per-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Command code |
| specialFn | input | 1 | Selects graphics variant of the command |
| bank | input | 1 | Bank select |
| addrIn | input | 9 | Column address, load selects, precharge-all bit |
| dataIn | input | 64 | Data bus word |
| laneMask | input | 8 | Per-byte-lane write mask, 1 = lane masked |
| busBusy | input | 1 | Data bus is carrying a burst |
| wrValid | output | 1 | Descriptor valid |
| wrBlock | output | 1 | Descriptor is a block write |
| wrBank | output | 1 | Target bank |
| wrCol | output | 8 | Target (base) column |
| wrData | output | 64 | Data or colour word |
| wrColLaneEn | output | 64 | Column-by-lane enable map, bit c*8+L |
| wrBitEn | output | 64 | Per-bit write enable |
| smrsErr | output | 1 | Rejected register load |
| ruleErr | output | 1 | Precharge too soon after block write |

## Verification
The hardest state to reach is one where the two banks hold different write-per-bit modes at the same time as a mask word that has been reloaded. In that state, a plain write and a block write to different banks must show different bit enables from the same shared mask. The stimulus reaches it by loading the mask, then opening one bank with the graphics flag and the other without it, and then closing each bank in turn, first with a single-bank precharge and then with a precharge-all. A long random phase then mixes every command with busy and double-select loads. A behavioural model tracks colour, mask, per-bank modes and recent block writes, and is compared with the outputs every cycle.

// File: rtl/blkwr_pkg.sv
package blkwr_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_WR  = 3'd2,
    CMD_PRE = 3'd3,
    CMD_MRS = 3'd4
  } cmd_e;

  typedef struct packed {
    logic loadColour;
    logic loadMask;
    logic doWrite;
    logic doBlock;
    logic useMask;
  } strobe_t;

endpackage

// File: rtl/blkwr_ctrl.sv
module blkwr_ctrl
  import blkwr_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmd,
  input  logic              specialFn,
  input  logic [BANK_W-1:0] bank,
  input  logic              preAllSel,
  input  logic              colourSel,
  input  logic              maskSel,
  input  logic              busBusy,
  output strobe_t           strb,
  output logic              smrsErr,
  output logic              ruleErr
);

  cmd_e cmdE;
  assign cmdE = cmd_e'(cmd);

  logic [NUM_BANKS-1:0] wpbQ;
  logic [NUM_BANKS-1:0] recentBwQ;
  logic [NUM_BANKS-1:0] preHit;
  logic [NUM_BANKS-1:0] bankHit;
  logic isSmrs;
  logic bothSel;
  logic smrsOk;
  logic ruleHit;

  always_comb begin
    isSmrs  = (cmdE == CMD_MRS) && specialFn;
    bothSel = colourSel && maskSel;
    smrsOk  = isSmrs && !busBusy && !bothSel;
    strb.loadColour = smrsOk && colourSel;
    strb.loadMask   = smrsOk && maskSel;
    strb.doWrite    = (cmdE == CMD_WR);
    strb.doBlock    = (cmdE == CMD_WR) && specialFn;
    strb.useMask    = wpbQ[bank];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign bankHit[b] = (bank == BANK_W'(b));
    assign preHit[b]  = (cmdE == CMD_PRE) && (preAllSel || bankHit[b]);
  end

  assign ruleHit = |(preHit & recentBwQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wpbQ      <= '0;
      recentBwQ <= '0;
      smrsErr   <= 1'b0;
      ruleErr   <= 1'b0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if ((cmdE == CMD_ACT) && bankHit[b]) wpbQ[b] <= specialFn;
        else if (preHit[b])                  wpbQ[b] <= 1'b0;
        recentBwQ[b] <= strb.doBlock && bankHit[b];
      end
      smrsErr <= isSmrs && (busBusy || bothSel);
      ruleErr <= ruleHit;
    end
  end

  // R7: a rejected load is only ever reported for a graphics register load
  a_r7_err_source: assert property (@(posedge clk) disable iff (!rstN)
    smrsErr |-> $past((cmdE == CMD_MRS) && specialFn));

  // R9: a rule error always follows a precharge command
  a_r9_rule_source: assert property (@(posedge clk) disable iff (!rstN)
    ruleErr |-> $past(cmdE == CMD_PRE));

  // R3: bank 0 enters write-per-bit mode only through a graphics activate
  a_r3_mode_from_act: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wpbQ[0]) |-> $past((cmdE == CMD_ACT) && specialFn && (bank == '0)));

endmodule

// File: rtl/blkwr_datapath.sv
module blkwr_datapath
  import blkwr_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LANE_W = 8,
  parameter int BANK_W = 1,
  parameter int COL_W  = 8
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          strb,
  input  logic [BANK_W-1:0]                bank,
  input  logic [COL_W-1:0]                 colAddr,
  input  logic [DATA_W-1:0]                dataIn,
  input  logic [DATA_W/LANE_W-1:0]         laneMask,
  output logic                             wrValid,
  output logic                             wrBlock,
  output logic [BANK_W-1:0]                wrBank,
  output logic [COL_W-1:0]                 wrCol,
  output logic [DATA_W-1:0]                wrData,
  output logic [LANE_W*DATA_W/LANE_W-1:0]  wrColLaneEn,
  output logic [DATA_W-1:0]                wrBitEn,
  output logic [DATA_W-1:0]                colourQ,
  output logic [DATA_W-1:0]                maskQ
);

  localparam int LANES      = DATA_W / LANE_W;
  localparam int BLOCK_COLS = LANE_W;
  localparam int CE_W       = BLOCK_COLS * LANES;
  localparam int BLK_SEL_W  = $clog2(BLOCK_COLS);

  logic [CE_W-1:0]   blkEn;
  logic [CE_W-1:0]   normEn;
  logic [DATA_W-1:0] bitEnNext;
  logic [COL_W-1:0]  colNext;

  // Lane bit c steers lane L of the colour word into column offset c
  for (genvar c = 0; c < BLOCK_COLS; c++) begin : g_col
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign blkEn[c*LANES + l] = dataIn[l*LANE_W + c] & ~laneMask[l];
    end
  end

  assign normEn    = {{(CE_W-LANES){1'b0}}, ~laneMask};
  assign bitEnNext = strb.useMask ? maskQ : {DATA_W{1'b1}};
  assign colNext   = strb.doBlock ? {colAddr[COL_W-1:BLK_SEL_W], {BLK_SEL_W{1'b0}}}
                                  : colAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colourQ <= '0;
      maskQ   <= '0;
    end else begin
      if (strb.loadColour) colourQ <= dataIn;
      if (strb.loadMask)   maskQ   <= dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrValid     <= 1'b0;
      wrBlock     <= 1'b0;
      wrBank      <= '0;
      wrCol       <= '0;
      wrData      <= '0;
      wrColLaneEn <= '0;
      wrBitEn     <= '0;
    end else if (strb.doWrite) begin
      wrValid     <= 1'b1;
      wrBlock     <= strb.doBlock;
      wrBank      <= bank;
      wrCol       <= colNext;
      wrData      <= strb.doBlock ? colourQ : dataIn;
      wrColLaneEn <= strb.doBlock ? blkEn : normEn;
      wrBitEn     <= bitEnNext;
    end else begin
      wrValid     <= 1'b0;
      wrBlock     <= 1'b0;
      wrBank      <= '0;
      wrCol       <= '0;
      wrData      <= '0;
      wrColLaneEn <= '0;
      wrBitEn     <= '0;
    end
  end

  // R5: block descriptors always name an aligned column group
  a_r5_block_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrBlock) |-> (wrCol[BLK_SEL_W-1:0] == '0));

  // R6: an accepted colour load is visible in the following cycle
  a_r6_colour_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadColour |=> (colourQ == $past(dataIn)));

  // R6: an accepted mask load is visible in the following cycle
  a_r6_mask_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadMask |=> (maskQ == $past(dataIn)));

  // R2: plain writes use only the first column slot
  a_r2_plain_slot: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrBlock) |-> (wrColLaneEn[CE_W-1:LANES] == '0));

endmodule

// File: rtl/blkwr_expand.sv
module blkwr_expand
  import blkwr_pkg::*;
#(
  parameter int DATA_W          = 64,
  parameter int LANE_W          = 8,
  parameter int NUM_BANKS       = 2,
  parameter int COL_W           = 8,
  parameter int ADDR_W          = 9,
  parameter int COLOUR_SEL_BIT  = 6,
  parameter int MASK_SEL_BIT    = 5,
  parameter int PRE_ALL_BIT     = 8,
  localparam int LANES          = DATA_W / LANE_W,
  localparam int CE_W           = LANE_W * LANES,
  localparam int BANK_W         = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmd,
  input  logic              specialFn,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [LANES-1:0]  laneMask,
  input  logic              busBusy,
  output logic              wrValid,
  output logic              wrBlock,
  output logic [BANK_W-1:0] wrBank,
  output logic [COL_W-1:0]  wrCol,
  output logic [DATA_W-1:0] wrData,
  output logic [CE_W-1:0]   wrColLaneEn,
  output logic [DATA_W-1:0] wrBitEn,
  output logic              smrsErr,
  output logic              ruleErr
);

  strobe_t           strb;
  logic [DATA_W-1:0] colourQ;
  logic [DATA_W-1:0] maskQ;

  blkwr_ctrl #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .specialFn (specialFn),
    .bank      (bank),
    .preAllSel (addrIn[PRE_ALL_BIT]),
    .colourSel (addrIn[COLOUR_SEL_BIT]),
    .maskSel   (addrIn[MASK_SEL_BIT]),
    .busBusy   (busBusy),
    .strb      (strb),
    .smrsErr   (smrsErr),
    .ruleErr   (ruleErr)
  );

  blkwr_datapath #(
    .DATA_W (DATA_W),
    .LANE_W (LANE_W),
    .BANK_W (BANK_W),
    .COL_W  (COL_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .bank        (bank),
    .colAddr     (addrIn[COL_W-1:0]),
    .dataIn      (dataIn),
    .laneMask    (laneMask),
    .wrValid     (wrValid),
    .wrBlock     (wrBlock),
    .wrBank      (wrBank),
    .wrCol       (wrCol),
    .wrData      (wrData),
    .wrColLaneEn (wrColLaneEn),
    .wrBitEn     (wrBitEn),
    .colourQ     (colourQ),
    .maskQ       (maskQ)
  );

  // R1: every write command yields a descriptor one cycle later
  a_r1_write_valid: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_WR) |=> wrValid);

  // R1: no descriptor without a write command
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cmd != CMD_WR) |=> !wrValid);

  // R8: a plain mode-register load leaves the graphics registers alone
  a_r8_plain_load_keeps: assert property (@(posedge clk) disable iff (!rstN)
    ((cmd == CMD_MRS) && !specialFn) |=> ($stable(colourQ) && $stable(maskQ)));

endmodule

// File: tb/blkwr_expand_bench.sv
module blkwr_expand_bench;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN;
  logic [2:0]  cmd;
  logic        specialFn;
  logic [0:0]  bank;
  logic [8:0]  addrIn;
  logic [63:0] dataIn;
  logic [7:0]  laneMask;
  logic        busBusy;
  logic        wrValid, wrBlock, smrsErr, ruleErr;
  logic [0:0]  wrBank;
  logic [7:0]  wrCol;
  logic [63:0] wrData, wrColLaneEn, wrBitEn;

  blkwr_expand u_blkwr_expand (
    .clk(clk), .rstN(rstN), .cmd(cmd), .specialFn(specialFn), .bank(bank),
    .addrIn(addrIn), .dataIn(dataIn), .laneMask(laneMask), .busBusy(busBusy),
    .wrValid(wrValid), .wrBlock(wrBlock), .wrBank(wrBank), .wrCol(wrCol),
    .wrData(wrData), .wrColLaneEn(wrColLaneEn), .wrBitEn(wrBitEn),
    .smrsErr(smrsErr), .ruleErr(ruleErr)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Behavioural reference state
  logic [63:0] mColour = '0;
  logic [63:0] mMask   = '0;
  logic [1:0]  mWpb    = '0;
  logic [1:0]  mRecent = '0;

  localparam logic [63:0] COLOUR_A = 64'hA1B2_C3D4_E5F6_0718;
  localparam logic [63:0] MASK_A   = 64'hF0F0_0FF0_FF00_00FF;

  task automatic chk(input string tag, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic s, input logic b,
                      input logic [8:0] a, input logic [63:0] d,
                      input logic [7:0] m, input logic bz);
    logic        isWr, isBlk, eSmrs, eRule, okLoad;
    logic [7:0]  eCol;
    logic [63:0] eData, eLane, eBit;
    cmd = c; specialFn = s; bank = b; addrIn = a; dataIn = d;
    laneMask = m; busBusy = bz;
    @(posedge clk);
    @(negedge clk);
    isWr  = (c == 3'd2);
    isBlk = isWr && s;
    eCol  = !isWr ? 8'h00 : (isBlk ? {a[7:3], 3'b000} : a[7:0]);
    eData = !isWr ? 64'h0 : (isBlk ? mColour : d);
    eLane = '0;
    if (isWr && !isBlk) eLane[7:0] = ~m;
    if (isBlk)
      for (int col = 0; col < 8; col++)
        for (int ln = 0; ln < 8; ln++)
          eLane[col*8 + ln] = d[ln*8 + col] & ~m[ln];
    eBit  = !isWr ? 64'h0 : (mWpb[b] ? mMask : {64{1'b1}});
    eSmrs = (c == 3'd4) && s && (bz || (a[6] && a[5]));
    eRule = (c == 3'd3) && (a[8] ? (mRecent[0] | mRecent[1]) : mRecent[b]);
    chk("R1", "wrValid", {63'b0, wrValid}, {63'b0, isWr});
    chk("R5", "wrBlock", {63'b0, wrBlock}, {63'b0, isBlk});
    chk("R1", "wrBank", {63'b0, wrBank}, {63'b0, isWr & b});
    chk(isBlk ? "R5" : "R2", "wrCol", {56'b0, wrCol}, {56'b0, eCol});
    chk(isBlk ? "R5" : "R2", "wrData", wrData, eData);
    chk(isBlk ? "R5" : "R2", "wrColLaneEn", wrColLaneEn, eLane);
    chk("R3", "wrBitEn", wrBitEn, eBit);
    chk("R7", "smrsErr", {63'b0, smrsErr}, {63'b0, eSmrs});
    chk("R9", "ruleErr", {63'b0, ruleErr}, {63'b0, eRule});
    // update reference state
    okLoad = (c == 3'd4) && s && !bz && !(a[6] && a[5]);
    if (okLoad && a[6]) mColour = d;
    if (okLoad && a[5]) mMask = d;
    if (c == 3'd1) mWpb[b] = s;
    if (c == 3'd3) begin
      if (a[8]) mWpb = '0;
      else      mWpb[b] = 1'b0;
    end
    mRecent = '0;
    if (isBlk) mRecent[b] = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    rstN = 1'b0; cmd = '0; specialFn = 0; bank = 0; addrIn = '0;
    dataIn = '0; laneMask = '0; busBusy = 0;
    repeat (3) @(negedge clk);
    // R10: reset state at the ports
    chk("R10", "wrValid", {63'b0, wrValid}, 64'h0);
    chk("R10", "wrData", wrData, 64'h0);
    chk("R10", "wrBitEn", wrBitEn, 64'h0);
    chk("R10", "errs", {62'b0, smrsErr, ruleErr}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R10: colour word starts at zero and write is unmasked
    step(3'd2, 1, 0, 9'h000, {64{1'b1}}, 8'h00, 0);
    chk("R10", "colour after reset", wrData, 64'h0);
    chk("R10", "unmasked after reset", wrBitEn, {64{1'b1}});

    // R2: plain writes with lane masks
    step(3'd2, 0, 0, 9'h02A, 64'h1122_3344_5566_7788, 8'h05, 0);
    step(3'd2, 0, 1, 9'h0FF, 64'hDEAD_BEEF_0BAD_F00D, 8'hFF, 0);
    step(3'd0, 0, 0, 9'h000, 64'h0, 8'h00, 0);

    // R6: load colour and mask on an idle bus
    step(3'd4, 1, 0, 9'h040, COLOUR_A, 8'h00, 0);
    step(3'd4, 1, 0, 9'h020, MASK_A, 8'h00, 0);

    // R5 / R6: block write with a diagonal enable pattern and one lane masked
    step(3'd2, 1, 0, 9'h057, 64'h8040_2010_0804_0201, 8'h10, 0);
    chk("R6", "block colour", wrData, COLOUR_A);
    chk("R5", "aligned column", {56'b0, wrCol}, 64'h50);
    step(3'd2, 1, 1, 9'h0C3, {64{1'b1}}, 8'h00, 0);

    // R3 / R4: write-per-bit mode per bank
    step(3'd1, 1, 0, 9'h000, 64'h0, 8'h00, 0);
    step(3'd1, 0, 1, 9'h000, 64'h0, 8'h00, 0);
    step(3'd2, 0, 0, 9'h011, 64'h0123_4567_89AB_CDEF, 8'h00, 0);
    chk("R3", "masked plain write", wrBitEn, MASK_A);
    step(3'd2, 0, 1, 9'h012, 64'h0123_4567_89AB_CDEF, 8'h00, 0);
    chk("R4", "other bank unmasked", wrBitEn, {64{1'b1}});
    step(3'd2, 1, 0, 9'h020, 64'hFF, 8'h00, 0);
    chk("R3", "masked block write", wrBitEn, MASK_A);
    step(3'd0, 0, 0, 9'h000, 64'h0, 8'h00, 0);
    step(3'd3, 0, 1, 9'h000, 64'h0, 8'h00, 0);
    step(3'd2, 0, 0, 9'h013, 64'h5, 8'h00, 0);
    chk("R3", "bank0 still masked", wrBitEn, MASK_A);
    step(3'd0, 0, 0, 9'h000, 64'h0, 8'h00, 0);
    step(3'd3, 0, 1, 9'h100, 64'h0, 8'h00, 0);
    step(3'd2, 0, 0, 9'h014, 64'h5, 8'h00, 0);
    chk("R3", "precharge-all clears mode", wrBitEn, {64{1'b1}});

    // R7: rejected loads
    step(3'd4, 1, 0, 9'h040, 64'h0, 8'h00, 1);
    chk("R7", "busy load error", {63'b0, smrsErr}, 64'h1);
    step(3'd4, 1, 0, 9'h060, 64'h0, 8'h00, 0);
    chk("R7", "double select error", {63'b0, smrsErr}, 64'h1);
    step(3'd2, 1, 0, 9'h000, 64'h1, 8'h00, 0);
    chk("R7", "colour kept", wrData, COLOUR_A);

    // R8: plain register load touches nothing
    step(3'd4, 0, 0, 9'h060, 64'h0, 8'h00, 0);
    chk("R8", "no error", {63'b0, smrsErr}, 64'h0);
    step(3'd1, 1, 0, 9'h000, 64'h0, 8'h00, 0);
    step(3'd2, 1, 0, 9'h000, 64'h1, 8'h00, 0);
    chk("R8", "colour kept", wrData, COLOUR_A);
    chk("R8", "mask kept", wrBitEn, MASK_A);

    // R9: precharge spacing after block writes
    step(3'd2, 1, 0, 9'h008, 64'h1, 8'h00, 0);
    step(3'd3, 0, 0, 9'h000, 64'h0, 8'h00, 0);
    chk("R9", "early precharge", {63'b0, ruleErr}, 64'h1);
    step(3'd2, 1, 1, 9'h008, 64'h1, 8'h00, 0);
    step(3'd2, 1, 1, 9'h010, 64'h1, 8'h00, 0);
    chk("R9", "back-to-back ok", {63'b0, ruleErr}, 64'h0);
    step(3'd0, 0, 0, 9'h000, 64'h0, 8'h00, 0);
    step(3'd3, 0, 1, 9'h000, 64'h0, 8'h00, 0);
    chk("R9", "spaced precharge ok", {63'b0, ruleErr}, 64'h0);
    step(3'd2, 1, 0, 9'h008, 64'h1, 8'h00, 0);
    step(3'd3, 0, 1, 9'h000, 64'h0, 8'h00, 0);
    chk("R9", "other bank ok", {63'b0, ruleErr}, 64'h0);
    step(3'd2, 1, 0, 9'h008, 64'h1, 8'h00, 0);
    step(3'd3, 0, 1, 9'h100, 64'h0, 8'h00, 0);
    chk("R9", "precharge-all early", {63'b0, ruleErr}, 64'h1);

    // Random mix, compared against the model every cycle (R1..R9)
    for (int i = 0; i < 600; i++) begin
      logic [2:0] rc;
      rc = 3'($urandom_range(0, 4));
      step(rc, 1'($urandom), 1'($urandom), 9'($urandom),
           {$urandom, $urandom}, 8'($urandom), 1'($urandom_range(0, 3) == 0));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule